// File: doc/BRIEF.md
# Multiprocessor Glue Register File

This block is a small memory-mapped control device for a multiprocessor system. It answers bus requests inside a 64-byte window. It exposes four registers: an exit register that stops the system and keeps a status byte, a read-only register that tells the requesting processor its own index, a read-only register that reports how many processors are fitted, and an interrupt-control register. A single write to the interrupt-control register picks one of the per-processor interrupt outputs and sets the level that output keeps driving.

Requests arrive on a simple synchronous bus. A request carries a valid strobe, a write flag, an address, a byte count, write data and the identity of the requesting processor. Read data comes back registered, one cycle after the request, with a valid strobe. Byte lanes are little-endian: the byte at the lower address travels on `bus_wdata[7:0]` and the next byte on `bus_wdata[15:8]`. The processor count is fixed at build time by a parameter.

Top module: `mp_glue_regs`

## Requirements
- R1: Only address bits [5:0] are decoded, so any address that is equal modulo 64 reaches the same register.
- R2: A read at offset 4 returns the requester index `bus_req_id`, zero-extended to 32 bits.
- R3: A read at offset 12 returns the parameter NPROC, the processor count, zero-extended to 32 bits.
- R4: A write at offset 0 raises `halt_pulse` for exactly the one cycle after the request, and `exit_code` takes `bus_wdata[7:0]` and keeps it until the next such write or reset.
- R5: A write at offset 8 with `bus_size` = 1 (two bytes) or 2 (four bytes) takes the port index from `bus_wdata[7:0]` and the level from `bus_wdata[15:8]`, and sets `irq_level[port]` to that level from the next cycle.
- R6: A write at offset 8 with `bus_size` = 0 (one byte) drives level 0 onto the selected port.
- R7: Each interrupt output keeps its level until an interrupt-control write names its port; writes naming other ports, or other registers, leave it unchanged.
- R8: Every read gives `rd_valid` high for exactly the following cycle; offsets other than 4 and 12 read as zero, and `rd_data` is zero whenever `rd_valid` is low.
- R9: An interrupt-control write whose port index is NPROC or above changes no output.
- R10: After reset all interrupt levels, `exit_code`, `halt_pulse`, `rd_valid` and `rd_data` are zero.
- R11: Writes at offsets 4 and 12 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Byte count code: 0 one, 1 two, 2 four |
| bus_wdata | input | 32 | Write data, lowest address in bits [7:0] |
| bus_req_id | input | ID_W | Index of the requesting processor |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| halt_pulse | output | 1 | One-cycle stop request |
| exit_code | output | 8 | Captured exit status |
| irq_level | output | NPROC x 8 | Held level for each processor interrupt |

## Verification
The processor-index read is tried with several distinct requester IDs, including at an aliased address, which tells a design that returns the requester apart from one that returns a constant or the count. Interrupt-control writes are tried with two-byte and one-byte sizes and with ports inside and beyond the fitted count, separating correct level selection from a wrong byte lane, a missing size check or an unguarded index. Reads at undefined offsets and writes to the read-only offsets between interrupt writes show that no other register disturbs the held levels or the exit status.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    typedef enum logic [2:0] {
        SEL_EXIT,
        SEL_CPUID,
        SEL_IRQ,
        SEL_COUNT,
        SEL_NONE
    } mpg_sel_e;

    localparam int WIN_BITS = 6;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } mpg_rd_t;

endpackage

// File: rtl/mpg_decode.sv
module mpg_decode
    import mpg_pkg::*;
(
    input  logic [WIN_BITS-1:0] offset,
    output mpg_sel_e            sel
);
    always_comb begin
        case (offset)
            6'd0:    sel = SEL_EXIT;
            6'd4:    sel = SEL_CPUID;
            6'd8:    sel = SEL_IRQ;
            6'd12:   sel = SEL_COUNT;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/mpg_halt.sv
module mpg_halt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output logic       halt_pulse,
    output logic [7:0] exit_code
);
    typedef struct packed {
        logic       pulse;
        logic [7:0] code;
    } halt_st_t;

    halt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = wr_en;
        if (wr_en) begin
            st_d.code = wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign halt_pulse = st_q.pulse;
    assign exit_code  = st_q.code;

    assert_halt_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (halt_pulse && exit_code == $past(wr_byte)));
    assert_halt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!halt_pulse && $stable(exit_code)));
endmodule

// File: rtl/mpg_irq_bank.sv
module mpg_irq_bank #(
    parameter int NPROC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wide,
    input  logic [7:0]            wr_port,
    input  logic [7:0]            wr_level,
    output logic [NPROC-1:0][7:0] levels
);
    logic [NPROC-1:0][7:0] lvl_d, lvl_q;
    logic                  port_ok;

    assign port_ok = (32'(wr_port) < NPROC);

    always_comb begin
        lvl_d = lvl_q;
        for (int i = 0; i < NPROC; i++) begin
            if (wr_en && port_ok && (32'(wr_port) == i)) begin
                lvl_d[i] = wide ? wr_level : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign levels = lvl_q;

    for (genvar g = 0; g < NPROC; g++) begin : g_chk
        assert_lvl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && 32'(wr_port) == g) |=> $stable(levels[g]));
        assert_lvl_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wide && 32'(wr_port) == g) |=> levels[g] == $past(wr_level));
        assert_lvl_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wide && 32'(wr_port) == g) |=> levels[g] == 8'h00);
    end
endmodule

// File: rtl/mp_glue_regs.sv
module mp_glue_regs
    import mpg_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int ADDR_W = 16,
    parameter int ID_W   = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [31:0]           bus_wdata,
    input  logic [ID_W-1:0]       bus_req_id,
    output logic                  rd_valid,
    output logic [31:0]           rd_data,
    output logic                  halt_pulse,
    output logic [7:0]            exit_code,
    output logic [NPROC-1:0][7:0] irq_level
);
    localparam logic [31:0] COUNT_VAL = 32'(NPROC);

    mpg_sel_e sel;
    logic     wr_req, rd_req;
    mpg_rd_t  rd_d, rd_q;

    assign wr_req = bus_valid && bus_write;
    assign rd_req = bus_valid && !bus_write;

    mpg_decode u_decode (
        .offset (bus_addr[WIN_BITS-1:0]),
        .sel    (sel)
    );

    mpg_halt u_halt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_req && sel == SEL_EXIT),
        .wr_byte    (bus_wdata[7:0]),
        .halt_pulse (halt_pulse),
        .exit_code  (exit_code)
    );

    mpg_irq_bank #(.NPROC(NPROC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req && sel == SEL_IRQ),
        .wide     (bus_size != 2'd0),
        .wr_port  (bus_wdata[7:0]),
        .wr_level (bus_wdata[15:8]),
        .levels   (irq_level)
    );

    always_comb begin
        rd_d = '0;
        if (rd_req) begin
            rd_d.valid = 1'b1;
            case (sel)
                SEL_CPUID: rd_d.data = 32'(bus_req_id);
                SEL_COUNT: rd_d.data = COUNT_VAL;
                default:   rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    assert_rd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && rd_data == '0));
    assert_rd_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_rd_cpuid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr[5:0] == 6'd4) |=> rd_data == 32'($past(bus_req_id)));
    assert_rd_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bus_addr[5:0] == 6'd12) |=> rd_data == NPROC);
    assert_ro_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (bus_addr[5:0] == 6'd4 || bus_addr[5:0] == 6'd12))
        |=> ($stable(irq_level) && $stable(exit_code) && !halt_pulse));
endmodule

// File: tb/mp_glue_regs_bench.sv
module mp_glue_regs_bench;
    localparam int NPROC  = 4;
    localparam int ADDR_W = 16;
    localparam int ID_W   = 2;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  bus_valid;
    logic                  bus_write;
    logic [ADDR_W-1:0]     bus_addr;
    logic [1:0]            bus_size;
    logic [31:0]           bus_wdata;
    logic [ID_W-1:0]       bus_req_id;
    logic                  rd_valid;
    logic [31:0]           rd_data;
    logic                  halt_pulse;
    logic [7:0]            exit_code;
    logic [NPROC-1:0][7:0] irq_level;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] exp_q[$];
    logic [7:0]  exp_lvl [NPROC];
    logic [7:0]  exp_code;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mp_glue_regs #(.NPROC(NPROC), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_mp_glue_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_req_id(bus_req_id), .rd_valid(rd_valid), .rd_data(rd_data),
        .halt_pulse(halt_pulse), .exit_code(exit_code), .irq_level(irq_level)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_levels(string req);
        for (int i = 0; i < NPROC; i++) begin
            check(req, 32'(irq_level[i]), 32'(exp_lvl[i]));
        end
    endtask

    // driver: read, pushes expected value for the monitor
    task automatic do_read(logic [ADDR_W-1:0] a, logic [ID_W-1:0] id, logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        bus_size = 2'd2; bus_wdata = '0; bus_req_id = id;
        exp_q.push_back(exp);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // driver: write; results visible at the following negedge
    task automatic do_write(logic [ADDR_W-1:0] a, logic [1:0] sz, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a;
        bus_size = sz; bus_wdata = d; bus_req_id = '0;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // monitor: compares every returned read against the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected read", 32'd1, 32'd0);
                end else begin
                    check("R2/R3/R8 read data", rd_data, exp_q.pop_front());
                end
            end else begin
                check("R8 idle data", rd_data, 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
        bus_size = '0; bus_wdata = '0; bus_req_id = '0;
        for (int i = 0; i < NPROC; i++) exp_lvl[i] = 8'h00;
        exp_code = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rd_valid", 32'(rd_valid), 0);
        check("R10 halt", 32'(halt_pulse), 0);
        check("R10 exit", 32'(exit_code), 0);
        check_levels("R10 levels");
        rst_n = 1'b1;

        // R2 requester index with several IDs
        do_read(16'h0004, 2'd0, 32'd0);
        do_read(16'h0004, 2'd2, 32'd2);
        do_read(16'h0004, 2'd3, 32'd3);
        // R1 aliasing
        do_read(16'h0044, 2'd1, 32'd1);
        do_read(16'h1F4C, 2'd1, NPROC);
        // R3 count
        do_read(16'h000C, 2'd3, NPROC);
        // R8 undefined / write-only offsets
        do_read(16'h0000, 2'd3, 32'd0);
        do_read(16'h0008, 2'd3, 32'd0);
        do_read(16'h0010, 2'd3, 32'd0);
        do_read(16'h003C, 2'd3, 32'd0);

        // R5 two-byte write
        do_write(16'h0008, 2'd1, 32'h0000_5A01);
        exp_lvl[1] = 8'h5A;
        check_levels("R5 set port1");
        // R5 four-byte write, R7 other port held
        do_write(16'h0008, 2'd2, 32'h0000_1103);
        exp_lvl[3] = 8'h11;
        check_levels("R7 port1 held");
        // R1 aliased interrupt write
        do_write(16'h0088, 2'd1, 32'h0000_3302);
        exp_lvl[2] = 8'h33;
        check_levels("R1 alias irq");
        // R6 one-byte write drives zero
        do_write(16'h0008, 2'd0, 32'h0000_7701);
        exp_lvl[1] = 8'h00;
        check_levels("R6 narrow write");
        // R9 out-of-range ports
        do_write(16'h0008, 2'd1, 32'h0000_FF04);
        check_levels("R9 port NPROC");
        do_write(16'h0008, 2'd1, 32'h0000_EEC8);
        check_levels("R9 port 200");
        // R11 writes to read-only offsets
        do_write(16'h0004, 2'd2, 32'h0000_9903);
        check_levels("R11 write cpuid");
        check("R11 no halt", 32'(halt_pulse), 0);
        do_write(16'h000C, 2'd2, 32'h0000_9902);
        check_levels("R11 write count");
        do_read(16'h000C, 2'd0, NPROC);
        do_read(16'h0004, 2'd1, 32'd1);
        // R7 hold over idle cycles
        repeat (5) @(negedge clk);
        check_levels("R7 idle hold");

        // R4 halt
        do_write(16'h0000, 2'd0, 32'h0000_002A);
        check("R4 pulse high", 32'(halt_pulse), 1);
        check("R4 exit code", 32'(exit_code), 32'h2A);
        @(negedge clk);
        check("R4 pulse one cycle", 32'(halt_pulse), 0);
        check("R4 exit held", 32'(exit_code), 32'h2A);
        do_write(16'h0040, 2'd0, 32'h0000_0081);
        check("R4 alias pulse", 32'(halt_pulse), 1);
        check("R4 alias code", 32'(exit_code), 32'h81);
        check_levels("R7 after halt");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule